// File: doc/BRIEF.md
# Prioritised Grouped Interrupt Controller

This block gathers interrupt requests from up to 124 sources, arranged as 31 groups of four request lines, and presents one prioritised maskable level plus a non-maskable pulse to a processor. Groups 0 and 1 are non-maskable: their requests are always enabled, and setting any of their request bits raises `nmi_pulse` for one cycle. Groups 2 to 30 are maskable. Each has a four-bit enable mask and a three-bit priority level, where a smaller number means a more urgent request.

Requests enter through per-line set strobes that an external capture stage drives, one bit per request line. Software reads and changes the request, enable and level state through a byte-wide register port. Each group has a four-byte window, and a separate accepted-group register sits above the windows. When the processor takes a maskable interrupt, it pulses `ack`. The controller then records which group was winning at that moment, and software can later read that group back.

There is no state machine in this block. Every register updates on the clock edge at which its strobe or write is seen, and the arbitration is pure combinational logic over the current register state.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset all request bits, levels and the accepted group are 0. Maskable enable masks are 0, non-maskable enables are all ones, `irq_level` is 7 and `nmi_pulse` is 0.
- R2: With `addr[7]`=0 the access goes to the window of group `addr[6:2]` at byte `addr[1:0]`. With `addr[7]`=1 it goes to the accepted-group register at byte `addr[1:0]`. Group index 31 reads 0 and ignores writes.
- R3: A maskable group reads `{req, req & en}` at byte 0 and `{1'b0, level, en}` at byte 1. Bytes 2 and 3 read 0.
- R4: A write to byte 0 of a maskable group handles each line i on its own, using the bit pair (`wdata[4+i]`, `wdata[i]`). The pair (1,1) sets the request bit, (0,1) clears it, and (1,0) and (0,0) leave it alone.
- R5: A write to byte 1 of a maskable group loads the level from `wdata[6:4]` and the enable mask from `wdata[3:0]`. Writes to bytes 2 and 3 change nothing.
- R6: `irq_level` shows the level of the winning maskable group, or 7 if there is none. A group can compete only if request AND enable is nonzero. The lowest level wins, and on equal levels the lower group number wins. A group at level 7 never wins. The output follows the register state of the current cycle.
- R7: At a clock edge with `ack` high, the winning group index is stored as the accepted group. If no group is winning, 0 is stored.
- R8: Byte 0 of the accepted-group register reads the accepted index shifted left by 2. It reads 0 if that group's request AND enable is zero now. The other bytes read 0, and writes to this register are ignored.
- R9: A non-maskable group reads its request bits at byte 0 in `[3:0]`. A write to byte 0 clears each request bit written as 1. A write to byte 3 sets each request bit written as 1. Bytes 1 and 2 read 0 and ignore writes.
- R10: `nmi_pulse` is high in the cycle after any clock edge at which a request bit of a non-maskable group is set, either by strobe or by a byte-3 write. Otherwise it is low.
- R11: At a clock edge, `req_set[4*g+i]` sets request bit i of group g. If a software clear hits the same bit at the same edge, the strobe wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | 124 | Per-line request-set strobes, bit 4*g+i for group g, line i |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr`, combinational |
| ack | input | 1 | Processor acknowledge of the current maskable level |
| irq_level | output | 3 | Winning maskable level, 7 when none |
| nmi_pulse | output | 1 | Non-maskable request pulse |

## Verification
The hardest situation to reach from the ports is an accepted group whose request disappears after the acknowledge. Setting this up takes a configured level, a pending request, an `ack` at the right cycle and then a clearing write before the readback. The directed part of the stimulus builds that sequence. It also covers an equal-level tie, a pending group stuck at level 7 and a strobe colliding with a clear on the same bit. After that, a long random phase of mixed writes, sparse strobes and acknowledges is compared every cycle with a behavioural model of all 31 groups.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    // The byte layouts fix four request lines per group.
    localparam int LINES_PER_GRP = 4;

    typedef enum logic [1:0] {
        OFS_REQ  = 2'd0,
        OFS_CFG  = 2'd1,
        OFS_RSV  = 2'd2,
        OFS_SETN = 2'd3
    } win_ofs_e;

    typedef struct packed {
        logic [LINES_PER_GRP-1:0] set;
        logic [LINES_PER_GRP-1:0] clr;
    } sw_req_t;

    // Turn one window write into set and clear masks for the request bits.
    function automatic sw_req_t decode_req_write(input logic is_nmi, input logic hit,
                                                 input logic [1:0] ofs, input logic [7:0] d);
        sw_req_t r;
        r.set = '0;
        r.clr = '0;
        if (hit) begin
            if (is_nmi) begin
                if (ofs == OFS_REQ)  r.clr = d[LINES_PER_GRP-1:0];
                if (ofs == OFS_SETN) r.set = d[LINES_PER_GRP-1:0];
            end else if (ofs == OFS_REQ) begin
                r.set = d[4 +: LINES_PER_GRP] & d[0 +: LINES_PER_GRP];
                r.clr = ~d[4 +: LINES_PER_GRP] & d[0 +: LINES_PER_GRP];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] req_o
);
    logic [N-1:0] req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~sw_clr) | sw_set | hw_set;
    end

    assign req_o = req_q;

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((req_q & $past(hw_set)) == $past(hw_set))); // R11

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sw_clr & ~sw_set & ~hw_set)) |=> ((req_q & $past(sw_clr & ~sw_set & ~hw_set)) == '0)); // R4
endmodule

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg #(
    parameter int N     = 4,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [LVL_W-1:0] lvl_in,
    input  logic [N-1:0]     en_in,
    output logic [LVL_W-1:0] lvl_o,
    output logic [N-1:0]     en_o
);
    logic [LVL_W-1:0] lvl_q;
    logic [N-1:0]     en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            en_q  <= '0;
        end else if (ld) begin
            lvl_q <= lvl_in;
            en_q  <= en_in;
        end
    end

    assign lvl_o = lvl_q;
    assign en_o  = en_q;

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (lvl_q == $past(lvl_in) && en_q == $past(en_in))); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(lvl_q) && $stable(en_q))); // R5
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int N          = 4,
    parameter int LVL_W      = 3,
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:NUM_NMI][N-1:0]     req,
    input  logic [NUM_GROUPS-1:NUM_NMI][N-1:0]     en,
    input  logic [NUM_GROUPS-1:NUM_NMI][LVL_W-1:0] lvl,
    output logic [GID_W-1:0]                       sel_id,
    output logic [LVL_W-1:0]                       sel_lvl,
    output logic                                   any_pend
);
    // Ascending scan with a strict compare: ties go to the lower group,
    // and the starting best of all ones means the lowest priority never wins.
    always_comb begin
        sel_id   = '0;
        sel_lvl  = '1;
        any_pend = 1'b0;
        for (int g = NUM_NMI; g < NUM_GROUPS; g++) begin
            if (|(req[g] & en[g])) begin
                any_pend = 1'b1;
                if (lvl[g] < sel_lvl) begin
                    sel_lvl = lvl[g];
                    sel_id  = GID_W'(g);
                end
            end
        end
    end
endmodule

// File: rtl/irqc_readback.sv
module irqc_readback #(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int N          = 4,
    parameter int LVL_W      = 3,
    parameter int ADDR_W     = 8,
    localparam int GID_W     = $clog2(NUM_GROUPS)
) (
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [NUM_GROUPS-1:0][N-1:0]           req,
    input  logic [NUM_GROUPS-1:0][N-1:0]           en,
    input  logic [NUM_GROUPS-1:NUM_NMI][LVL_W-1:0] lvl,
    input  logic [GID_W-1:0]                       acc_id,
    output logic [7:0]                             rdata
);
    logic [GID_W-1:0] gid;
    logic [1:0]       ofs;

    assign gid = addr[GID_W+1:2];
    assign ofs = addr[1:0];

    always_comb begin
        rdata = '0;
        if (addr[ADDR_W-1]) begin
            if (ofs == 2'd0 && (|(req[acc_id] & en[acc_id])))
                rdata = 8'({acc_id, 2'b00});
        end else if (int'(gid) < NUM_GROUPS) begin
            if (int'(gid) < NUM_NMI) begin
                if (ofs == 2'd0) rdata = 8'(req[gid]);
            end else begin
                unique case (ofs)
                    2'd0:    rdata = 8'({req[gid], req[gid] & en[gid]});
                    2'd1:    rdata = 8'({lvl[gid], en[gid]});
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int LVL_W      = 3,
    parameter int ADDR_W     = 8,
    localparam int N         = irqc_pkg::LINES_PER_GRP,
    localparam int GID_W     = $clog2(NUM_GROUPS),
    localparam int NLINES    = NUM_GROUPS * N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_set,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              ack,
    output logic [LVL_W-1:0]  irq_level,
    output logic              nmi_pulse
);
    import irqc_pkg::*;

    logic [NUM_GROUPS-1:0][N-1:0]           req_all;
    logic [NUM_GROUPS-1:0][N-1:0]           en_all;
    logic [NUM_GROUPS-1:NUM_NMI][LVL_W-1:0] lvl_all;
    logic [NUM_NMI-1:0]                     nmi_hit;
    logic [GID_W-1:0]                       sel_id;
    logic [LVL_W-1:0]                       sel_lvl;
    logic                                   any_pend;
    logic [GID_W-1:0]                       acc_q;
    logic                                   nmi_q;
    logic                                   win_wr;

    assign win_wr = wr_en && !addr[ADDR_W-1];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic    hit;
        sw_req_t sw;

        assign hit = win_wr && (addr[GID_W+1:2] == GID_W'(g));
        assign sw  = decode_req_write(g < NUM_NMI, hit, addr[1:0], wdata);

        irqc_req_bank #(.N(N)) u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (req_set[g*N +: N]),
            .sw_set (sw.set),
            .sw_clr (sw.clr),
            .req_o  (req_all[g])
        );

        if (g < NUM_NMI) begin : g_nmi
            assign en_all[g]  = '1;
            assign nmi_hit[g] = |(req_set[g*N +: N] | sw.set);
        end else begin : g_mask
            irqc_cfg_reg #(.N(N), .LVL_W(LVL_W)) u_cfg (
                .clk    (clk),
                .rst_n  (rst_n),
                .ld     (hit && addr[1:0] == OFS_CFG),
                .lvl_in (wdata[4 +: LVL_W]),
                .en_in  (wdata[N-1:0]),
                .lvl_o  (lvl_all[g]),
                .en_o   (en_all[g])
            );
        end
    end

    irqc_arbiter #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .N(N), .LVL_W(LVL_W)) u_arb (
        .req      (req_all[NUM_GROUPS-1:NUM_NMI]),
        .en       (en_all[NUM_GROUPS-1:NUM_NMI]),
        .lvl      (lvl_all),
        .sel_id   (sel_id),
        .sel_lvl  (sel_lvl),
        .any_pend (any_pend)
    );

    irqc_readback #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .N(N), .LVL_W(LVL_W),
                    .ADDR_W(ADDR_W)) u_rd (
        .addr   (addr),
        .req    (req_all),
        .en     (en_all),
        .lvl    (lvl_all),
        .acc_id (acc_q),
        .rdata  (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            if (ack) acc_q <= sel_id;
            nmi_q <= |nmi_hit;
        end
    end

    assign irq_level = sel_lvl;
    assign nmi_pulse = nmi_q;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |-> irq_level == {LVL_W{1'b1}}); // R6

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level != {LVL_W{1'b1}} |-> (int'(sel_id) >= NUM_NMI && (|(req_all[sel_id] & en_all[sel_id])))); // R6

    AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> acc_q == $past(sel_id)); // R7

    AST_ACC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1] && !ack) |=> $stable(acc_q)); // R8

    AST_NMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> $past(|nmi_hit)); // R10
endmodule

// File: tb/test_grp_irq_ctrl.sv
module test_grp_irq_ctrl;
    localparam int NG = 31;
    localparam int NN = 2;
    localparam int NL = NG * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] req_set = '0;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          ack = 1'b0;
    logic [2:0]    irq_level;
    logic          nmi_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    int m_req[NG];
    int m_en[NG];
    int m_lvl[NG];
    int m_acc;
    int m_nmi;

    always #5 clk = ~clk;

    grp_irq_ctrl i_grp_irq_ctrl (
        .clk (clk), .rst_n (rst_n), .req_set (req_set), .addr (addr),
        .wr_en (wr_en), .wdata (wdata), .rdata (rdata), .ack (ack),
        .irq_level (irq_level), .nmi_pulse (nmi_pulse)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int msel();
        int best = 7;
        int id = 0;
        for (int g = NN; g < NG; g++)
            if ((m_req[g] & m_en[g]) != 0 && m_lvl[g] < best) begin
                best = m_lvl[g];
                id = g;
            end
        return id;
    endfunction

    function automatic int mlevel();
        int s = msel();
        return (s == 0) ? 7 : m_lvl[s];
    endfunction

    function automatic int mread(input int a);
        int g = (a % 128) / 4;
        int o = a % 4;
        if (a >= 128)
            return (o == 0 && (m_req[m_acc] & m_en[m_acc]) != 0) ? m_acc * 4 : 0;
        if (g >= NG) return 0;
        if (g < NN) return (o == 0) ? m_req[g] : 0;
        if (o == 0) return m_req[g] * 16 + (m_req[g] & m_en[g]);
        if (o == 1) return m_lvl[g] * 16 + m_en[g];
        return 0;
    endfunction

    function automatic string rtag(input int a);
        if (a >= 128) return "R8";
        if (a / 4 >= NG) return "R2";
        if (a / 4 < NN) return "R9";
        return "R3";
    endfunction

    task automatic mupdate(input bit w, input int a, input int d, input logic [NL-1:0] hs, input bit k);
        int s = msel();
        int nmi = 0;
        int g = a / 4;
        int o = a % 4;
        if (w && a < 128 && g < NG) begin
            if (g < NN) begin
                if (o == 0) m_req[g] = m_req[g] & ~(d & 15);
                if (o == 3) begin
                    m_req[g] = m_req[g] | (d & 15);
                    if ((d & 15) != 0) nmi = 1;
                end
            end else begin
                if (o == 0)
                    for (int i = 0; i < 4; i++) begin
                        if (d[i] && d[i+4])  m_req[g] |= (1 << i);
                        if (d[i] && !d[i+4]) m_req[g] &= ~(1 << i);
                    end
                if (o == 1) begin
                    m_lvl[g] = (d / 16) % 8;
                    m_en[g]  = d % 16;
                end
            end
        end
        for (int b = 0; b < NL; b++)
            if (hs[b]) begin
                m_req[b / 4] |= (1 << (b % 4));
                if (b / 4 < NN) nmi = 1;
            end
        if (k) m_acc = s;
        m_nmi = nmi;
    endtask

    task automatic step(input bit w, input int a, input int d, input logic [NL-1:0] hs, input bit k);
        wr_en = w; addr = 8'(a); wdata = 8'(d); req_set = hs; ack = k;
        #1;
        chk(int'(rdata), mread(a), rtag(a));
        @(posedge clk);
        mupdate(w, a, d, hs, k);
        #1;
        chk(int'(irq_level), mlevel(), "R6");
        chk(int'(nmi_pulse), m_nmi, "R10");
        @(negedge clk);
        wr_en = 1'b0; req_set = '0; ack = 1'b0;
    endtask

    function automatic logic [NL-1:0] bitv(input int b);
        logic [NL-1:0] v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    initial begin
        for (int g = 0; g < NG; g++) begin
            m_req[g] = 0; m_lvl[g] = 0; m_en[g] = (g < NN) ? 15 : 0;
        end
        m_acc = 0; m_nmi = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk(int'(irq_level), 7, "R1");
        chk(int'(nmi_pulse), 0, "R1");
        addr = 8'(2*4+1); #1; chk(int'(rdata), 0, "R1");
        addr = 8'h80;     #1; chk(int'(rdata), 0, "R1");
        @(negedge clk);

        // R5: configure groups 3 and 5 at level 4, all lines enabled
        step(1, 3*4+1, 8'h4F, '0, 0);
        step(1, 5*4+1, 8'h4F, '0, 0);
        step(0, 5*4+1, 0, '0, 0);
        // R5: writes to bytes 2 and 3 of a maskable group are ignored
        step(1, 5*4+2, 8'hFF, '0, 0);
        step(1, 5*4+3, 8'hFF, '0, 0);
        step(0, 5*4+0, 0, '0, 0);
        step(0, 5*4+1, 0, '0, 0);
        // R4: pair (1,1) sets line 0 of group 5
        step(1, 5*4+0, 8'h11, '0, 0);
        step(0, 5*4+0, 0, '0, 0);
        // R4: pair (1,0) leaves it alone
        step(1, 5*4+0, 8'h10, '0, 0);
        step(0, 5*4+0, 0, '0, 0);
        // R11 and R6: strobe on group 3 line 2; equal level tie goes to group 3
        step(0, 3*4+0, 0, bitv(3*4+2), 0);
        // R7: acknowledge latches group 3, then R8 readback gives 0x0C
        step(0, 8'h80, 0, '0, 1);
        step(0, 8'h80, 0, '0, 0);
        // R8: write to the accepted register is ignored
        step(1, 8'h80, 8'h7C, '0, 0);
        step(0, 8'h81, 0, '0, 0);
        // R4: pair (0,1) clears line 2 of group 3, so the accepted read vanishes (R8)
        step(1, 3*4+0, 8'h04, '0, 0);
        step(0, 8'h80, 0, '0, 0);
        // R6: a lower level number takes over
        step(1, 9*4+1, 8'h2F, '0, 0);
        step(1, 9*4+0, 8'h88, '0, 0);
        step(0, 9*4+0, 0, '0, 0);
        // R6: level 7 never wins: clear 5 and 9, leave group 10 pending at level 7
        step(1, 5*4+0, 8'h01, '0, 0);
        step(1, 9*4+0, 8'h08, '0, 0);
        step(1, 10*4+1, 8'h7F, '0, 0);
        step(1, 10*4+0, 8'h11, '0, 0);
        // R7: acknowledge with no winner stores group 0
        step(0, 8'h80, 0, '0, 1);
        step(0, 8'h80, 0, '0, 0);
        // R11: strobe and software clear on the same bit: the strobe wins
        step(1, 5*4+0, 8'h02, bitv(5*4+1), 0);
        step(0, 5*4+0, 0, '0, 0);
        // R9, R10: byte-3 write sets and pulses, byte-0 write clears
        step(1, 1*4+3, 8'h04, '0, 0);
        step(0, 1*4+0, 0, '0, 0);
        step(1, 1*4+1, 8'hFF, '0, 0);
        step(0, 1*4+1, 0, '0, 0);
        step(1, 1*4+0, 8'h04, '0, 0);
        step(0, 1*4+0, 0, '0, 0);
        // R10: strobe on group 0 pulses for one cycle
        step(0, 0, 0, bitv(0), 0);
        step(0, 0, 0, '0, 0);
        // R2: group index 31 reads 0 and ignores writes
        step(1, 31*4+0, 8'hFF, '0, 0);
        step(1, 31*4+1, 8'hFF, '0, 0);
        step(0, 31*4+1, 0, '0, 0);

        // Random phase, compared with the model every cycle
        for (int n = 0; n < 3000; n++) begin
            int a;
            logic [NL-1:0] hs = '0;
            if ($urandom % 10 < 8) a = int'($urandom % 32) * 4 + int'($urandom % 4);
            else a = 128 + int'($urandom % 4);
            if ($urandom % 4 == 0) hs[$urandom % NL] = 1'b1;
            step(bit'($urandom % 2), a, int'($urandom % 256), hs, ($urandom % 8) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule